// File: doc/BRIEF.md
# Scan-Chained Pipeline Buffer Array

This block is an array of independent data lanes. Each lane is a short pipeline of one-entry valid/ready buffer stages. Every stage also carries a serial shift register, and the registers of a lane are linked end to end into one scan chain per lane. A tester drives all chains together through a clocked port set: a shift enable, a serial input and output per chain, and an update strobe.

With shift enable low and no command armed, each stage is a plain registered buffer. Tokens move one stage per clock at full throughput under backpressure. Shifting loads each stage's register with a command and a data word. The update strobe then applies every command at once.

There are three commands:
- A stage told to inject sends its scanned word downstream as one token.
- A stage told to drain swallows the tokens that reach it. It keeps the last one in its register, so a later shift can read it out.
- A stage told to skip stays transparent.

While shifting is in progress the whole data path is frozen.

Top module: `scanbuf_ctrl`

## Requirements
- R1: With shift enable low and all stages in skip, each lane delivers accepted tokens in order. A token spends one cycle in each stage. A lane accepts a token every cycle while its output is ready.
- R2: While a lane presents a token and out_ready is low, out_valid stays high and out_data stays unchanged.
- R3: There are NUM_CHAINS independent chains. Each stage holds a DATA_W+2 bit shift register. scan_in feeds stage 0 and the last stage drives scan_out. While scan_en is high, every chain shifts one bit per clock and scan_out shows the top bit of the last stage.
- R4: The top two bits of a stage's register hold the command and the lower DATA_W bits hold the word, so the command bits go in first. The encodings are: 00 skip, 01 inject, 10 drain, 11 skip. Within each field the most significant bit is shifted first.
- R5: A pulse on scan_upd with scan_en low applies every stage's command at the next clock edge. A pulse on scan_upd while scan_en is high has no effect.
- R6: While scan_en is high, every in_ready and every out_valid is low, and tokens held in the stages are kept.
- R7: After an inject update, the stage offers its scanned word as a token in the next cycle and holds it until it is taken. Meanwhile it refuses upstream tokens. Afterwards it behaves as skip.
- R8: A stage in drain accepts every token offered to it and forwards none of them. Each token overwrites the stage's scanned word, so a later shift reads out the last one.
- R9: A skip stage behaves exactly like a stage in normal mode.
- R10: A token moved in the same cycle as an update is handled under the mode in force before that update.
- R11: After reset all stages are empty and in skip, no inject is pending, all shift registers are zero, and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared by the data path and the tester port |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NUM_CHAINS | Token offered to each lane |
| in_data | input | NUM_CHAINS*DATA_W | Token words, lane l at bits l*DATA_W upward |
| in_ready | output | NUM_CHAINS | Lane accepts the offered token |
| out_valid | output | NUM_CHAINS | Lane presents a token |
| out_data | output | NUM_CHAINS*DATA_W | Presented words, packed as in_data |
| out_ready | input | NUM_CHAINS | Downstream takes the presented token |
| scan_en | input | 1 | Shift all chains and freeze the data path |
| scan_upd | input | 1 | Apply shifted commands to all stages |
| scan_in | input | NUM_CHAINS | Serial input of each chain |
| scan_out | output | NUM_CHAINS | Serial output of each chain |

## Verification
A command update can arrive in the same cycle as a token moves through the stage whose mode it changes. The bench provokes this by pulsing scan_upd in the same cycle that it offers a token to a lane whose first stage is about to turn into a drain. That first token must still reach the output. The next token must be swallowed and read back through the chain as the captured word. A second collision is an update pulse raised while shifting. It is judged by confirming that no injected token appears once shifting stops.

// File: rtl/scanbuf_pkg.sv
package scanbuf_pkg;

    localparam int CMD_W = 2;

    typedef enum logic [CMD_W-1:0] {
        CMD_SKIP   = 2'b00,
        CMD_INJECT = 2'b01,
        CMD_DRAIN  = 2'b10,
        CMD_SPARE  = 2'b11
    } scan_cmd_e;

    typedef struct packed {
        logic drain;
        logic inject;
    } stage_mode_t;

    function automatic stage_mode_t decode_cmd(input logic [CMD_W-1:0] c);
        stage_mode_t m;
        m.drain  = (c == CMD_DRAIN);
        m.inject = (c == CMD_INJECT);
        return m;
    endfunction

endpackage

// File: rtl/scanbuf_stage.sv
module scanbuf_stage
    import scanbuf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frz,
    input  logic              upd,
    input  logic              si,
    output logic              so,
    input  logic              i_valid,
    input  logic [DATA_W-1:0] i_data,
    output logic              i_ready,
    output logic              o_valid,
    output logic [DATA_W-1:0] o_data,
    input  logic              o_ready
);
    localparam int SRW = DATA_W + CMD_W;

    logic [SRW-1:0]    sr;
    logic [CMD_W-1:0]  sr_cmd;
    logic [DATA_W-1:0] sr_word;
    logic              drain_md;
    logic              inj_pend;
    logic              buf_v;
    logic [DATA_W-1:0] buf_d;
    stage_mode_t       nxt_mode;
    logic              acc;
    logic              dep;

    assign sr_cmd   = sr[SRW-1 -: CMD_W];
    assign sr_word  = sr[DATA_W-1:0];
    assign nxt_mode = decode_cmd(sr_cmd);
    assign so       = sr[SRW-1];

    assign o_valid = !frz && (inj_pend || buf_v);
    assign o_data  = inj_pend ? sr_word : buf_d;
    assign i_ready = !frz && !inj_pend && (drain_md || !buf_v || o_ready);
    assign acc     = i_valid && i_ready;
    assign dep     = o_valid && o_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr       <= '0;
            drain_md <= 1'b0;
            inj_pend <= 1'b0;
            buf_v    <= 1'b0;
            buf_d    <= '0;
        end else begin
            if (frz) begin
                sr <= {sr[SRW-2:0], si};
            end else if (drain_md && acc) begin
                sr[DATA_W-1:0] <= i_data;
            end
            if (dep && !inj_pend) begin
                buf_v <= 1'b0;
            end
            if (!drain_md && acc) begin
                buf_v <= 1'b1;
                buf_d <= i_data;
            end
            if (upd && !frz) begin
                inj_pend <= nxt_mode.inject;
                drain_md <= nxt_mode.drain;
            end else if (dep && inj_pend) begin
                inj_pend <= 1'b0;
            end
        end
    end

    p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        frz |-> (!o_valid && !i_ready));

    p_shift_step_r3: assert property (@(posedge clk) disable iff (rst)
        frz |=> (so == $past(sr[SRW-2])));

    p_hold_out_r2: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !o_ready && !frz && !upd) |=> $stable(o_data));

    p_inject_show_r7: assert property (@(posedge clk) disable iff (rst)
        (upd && !frz && !drain_md && sr_cmd == CMD_INJECT)
            |=> (frz || (o_valid && o_data == $past(sr_word))));

    p_drain_takes_r8: assert property (@(posedge clk) disable iff (rst)
        (drain_md && !inj_pend && !frz && i_valid) |-> i_ready);

    p_upd_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (frz && upd) |=> ($stable(drain_md) && $stable(inj_pend)));

endmodule

// File: rtl/scanbuf_chain.sv
module scanbuf_chain #(
    parameter int NUM_STAGES = 2,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_en,
    input  logic              scan_upd,
    input  logic              scan_in,
    output logic              scan_out,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready
);
    logic              lv [NUM_STAGES+1];
    logic              lr [NUM_STAGES+1];
    logic [DATA_W-1:0] ld [NUM_STAGES+1];
    logic              ls [NUM_STAGES+1];

    assign lv[0]     = in_valid;
    assign ld[0]     = in_data;
    assign ls[0]     = scan_in;
    assign in_ready  = lr[0];
    assign out_valid = lv[NUM_STAGES];
    assign out_data  = ld[NUM_STAGES];
    assign scan_out  = ls[NUM_STAGES];
    assign lr[NUM_STAGES] = out_ready;

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        scanbuf_stage #(.DATA_W(DATA_W)) stage_i (
            .clk     (clk),
            .rst     (rst),
            .frz     (scan_en),
            .upd     (scan_upd),
            .si      (ls[s]),
            .so      (ls[s+1]),
            .i_valid (lv[s]),
            .i_data  (ld[s]),
            .i_ready (lr[s]),
            .o_valid (lv[s+1]),
            .o_data  (ld[s+1]),
            .o_ready (lr[s+1])
        );
    end

endmodule

// File: rtl/scanbuf_ctrl.sv
module scanbuf_ctrl #(
    parameter int NUM_CHAINS = 16,
    parameter int NUM_STAGES = 2,
    parameter int DATA_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_CHAINS-1:0]        in_valid,
    input  logic [NUM_CHAINS*DATA_W-1:0] in_data,
    output logic [NUM_CHAINS-1:0]        in_ready,
    output logic [NUM_CHAINS-1:0]        out_valid,
    output logic [NUM_CHAINS*DATA_W-1:0] out_data,
    input  logic [NUM_CHAINS-1:0]        out_ready,
    input  logic                         scan_en,
    input  logic                         scan_upd,
    input  logic [NUM_CHAINS-1:0]        scan_in,
    output logic [NUM_CHAINS-1:0]        scan_out
);
    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_lane
        scanbuf_chain #(
            .NUM_STAGES (NUM_STAGES),
            .DATA_W     (DATA_W)
        ) chain_i (
            .clk       (clk),
            .rst       (rst),
            .scan_en   (scan_en),
            .scan_upd  (scan_upd),
            .scan_in   (scan_in[c]),
            .scan_out  (scan_out[c]),
            .in_valid  (in_valid[c]),
            .in_data   (in_data[c*DATA_W +: DATA_W]),
            .in_ready  (in_ready[c]),
            .out_valid (out_valid[c]),
            .out_data  (out_data[c*DATA_W +: DATA_W]),
            .out_ready (out_ready[c])
        );
    end

    p_quiet_after_reset_r11: assert property (@(posedge clk)
        $past(rst) |-> (out_valid == '0));

endmodule

// File: tb/scanbuf_ctrl_tb_top.sv
`timescale 1ns/1ps
module scanbuf_ctrl_tb_top;
    localparam int NC  = 2;
    localparam int NS  = 2;
    localparam int W   = 8;
    localparam int SRW = W + 2;
    localparam int CL  = NS * SRW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst;
    logic [NC-1:0]   in_valid, in_ready, out_valid, out_ready, scan_in, scan_out;
    logic [NC*W-1:0] in_data, out_data;
    logic            scan_en, scan_upd;

    scanbuf_ctrl #(.NUM_CHAINS(NC), .NUM_STAGES(NS), .DATA_W(W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .scan_en(scan_en), .scan_upd(scan_upd),
        .scan_in(scan_in), .scan_out(scan_out)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    string cur_req = "R1";
    logic [W-1:0] expq [NC][$];
    bit lane_pass [NC];
    bit acc [NC];
    bit hold_prev [NC];
    logic [W-1:0] hold_d [NC];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // one clock: sample handshakes before the edge, return at the next negedge
    task automatic step();
        #1;
        for (int l = 0; l < NC; l++) begin
            acc[l] = in_valid[l] && in_ready[l];
            if (hold_prev[l] && !scan_en)
                check(out_valid[l] && out_data[l*W +: W] == hold_d[l], "R2",
                      "held token", out_data[l*W +: W], hold_d[l]);
            if (acc[l] && lane_pass[l]) expq[l].push_back(in_data[l*W +: W]);
            if (out_valid[l] && out_ready[l]) begin
                if (expq[l].size() == 0)
                    check(0, cur_req, "unexpected token", out_data[l*W +: W], 0);
                else begin
                    logic [W-1:0] e;
                    e = expq[l].pop_front();
                    check(out_data[l*W +: W] == e, cur_req, "token order", out_data[l*W +: W], e);
                end
            end
            hold_prev[l] = out_valid[l] && !out_ready[l] && !scan_en && !scan_upd;
            hold_d[l]    = out_data[l*W +: W];
        end
        @(negedge clk);
    endtask

    // shift full words into both chains, collecting what leaves
    task automatic load(input logic [CL-1:0] p0, input logic [CL-1:0] p1,
                        output logic [CL-1:0] o0, output logic [CL-1:0] o1);
        in_valid = '0;
        scan_en  = 1'b1;
        for (int i = CL - 1; i >= 0; i--) begin
            o0[i] = scan_out[0];
            o1[i] = scan_out[1];
            scan_in = {p1[i], p0[i]};
            @(negedge clk);
        end
        scan_en = 1'b0;
        scan_in = '0;
        for (int l = 0; l < NC; l++) hold_prev[l] = 0;
    endtask

    task automatic pulse_upd();
        scan_upd = 1'b1;
        step();
        scan_upd = 1'b0;
    endtask

    task automatic t_reset();
        check(out_valid == '0, "R11", "out_valid after reset", out_valid, 0);
        check(scan_out == '0, "R11", "scan_out after reset", scan_out, 0);
        check(in_ready == '1, "R11", "in_ready after reset", in_ready, 3);
    endtask

    task automatic t_stream();
        int n_acc = 0;
        cur_req = "R1";
        out_ready = '1;
        for (int i = 0; i < 6; i++) begin
            in_valid = '1;
            in_data  = {W'(8'h40 + i), W'(8'h10 + i)};
            step();
            if (acc[0] && acc[1]) n_acc++;
        end
        in_valid = '0;
        repeat (4) step();
        check(n_acc == 6, "R1", "accepts in 6 cycles", n_acc, 6);
        check(expq[0].size() == 0 && expq[1].size() == 0, "R1", "all delivered",
              expq[0].size() + expq[1].size(), 0);
    endtask

    task automatic t_backpressure();
        int cyc = 0;
        cur_req = "R2";
        for (int i = 0; i < 6; i++) begin
            in_valid[0] = 1'b1;
            in_data[W-1:0] = W'(8'hB0 + i);
            do begin
                out_ready = {1'b1, (cyc % 3 == 0)};
                cyc++;
                step();
            end while (!acc[0]);
        end
        in_valid = '0;
        out_ready = '1;
        repeat (4) step();
        check(expq[0].size() == 0, "R2", "drained after backpressure", expq[0].size(), 0);
    endtask

    task automatic t_freeze();
        cur_req = "R6";
        out_ready = '0;
        in_valid = 2'b01;
        in_data[W-1:0] = 8'hE1;
        step();
        in_valid = 2'b10;
        in_data[2*W-1:W] = 8'hE2;
        scan_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            check(out_valid == '0, "R6", "out_valid frozen", out_valid, 0);
            check(!acc[1], "R6", "frozen accept", acc[1], 0);
        end
        scan_en = 1'b0;
        in_valid = '0;
        out_ready = '1;
        repeat (4) step();
        check(expq[0].size() == 0, "R6", "kept token released", expq[0].size(), 0);
    endtask

    task automatic t_scan_through();
        logic [CL-1:0] o0, o1;
        logic [CL-1:0] alt;
        alt = {CL/2{2'b01}};
        load(20'hC3A5F, 20'h1B2D4, o0, o1);
        load(alt, alt, o0, o1);
        check(o0 == 20'hC3A5F, "R3", "chain0 read back", o0, 20'hC3A5F);
        check(o1 == 20'h1B2D4, "R3", "chain1 read back", o1, 20'h1B2D4);
        // both stages now hold command 01; pulse update while still shifting
        scan_en = 1'b1;
        scan_in = '0;
        scan_upd = 1'b1;
        @(negedge clk);
        scan_upd = 1'b0;
        scan_in = '1;
        @(negedge clk);
        scan_en = 1'b0;
        scan_in = '0;
        cur_req = "R5";
        repeat (3) begin
            step();
            check(out_valid == '0, "R5", "update during shift ignored", out_valid, 0);
        end
    endtask

    task automatic t_inject();
        logic [CL-1:0] o0, o1;
        cur_req = "R7";
        // last stage first: inject 0xA5; stage 0 skip
        load({2'b01, 8'hA5, 2'b00, 8'h00}, '0, o0, o1);
        out_ready = '0;
        expq[0].push_back(8'hA5);
        pulse_upd();
        check(out_valid[0] && out_data[W-1:0] == 8'hA5, "R7", "injected word shown",
              out_data[W-1:0], 8'hA5);
        check(!out_valid[1], "R4", "skip chain idle", out_valid[1], 0);
        in_valid = 2'b01;
        in_data[W-1:0] = 8'h3C;
        step();
        in_valid = '0;
        repeat (2) step();
        check(out_data[W-1:0] == 8'hA5 && !in_ready[0], "R7", "inject holds, upstream stalled",
              out_data[W-1:0], 8'hA5);
        cur_req = "R9";
        out_ready = '1;
        repeat (4) step();
        check(expq[0].size() == 0, "R9", "token after inject passed", expq[0].size(), 0);
    endtask

    task automatic t_drain();
        logic [CL-1:0] o0, o1;
        cur_req = "R8";
        load({2'b00, 8'h00, 2'b10, 8'h00}, '0, o0, o1);
        pulse_upd();
        lane_pass[0] = 0;
        out_ready = '1;
        for (int i = 0; i < 3; i++) begin
            in_valid = 2'b01;
            in_data[W-1:0] = W'(8'h11 * (i + 1));
            step();
            check(acc[0], "R8", "drain accepts", acc[0], 1);
        end
        in_valid = '0;
        repeat (3) step();
        lane_pass[0] = 1;
        load('0, '0, o0, o1);
        check(o0[SRW-1:0] == {2'b10, 8'h33}, "R8", "captured word", o0[SRW-1:0], {2'b10, 8'h33});
        pulse_upd();
    endtask

    task automatic t_same_cycle();
        logic [CL-1:0] o0, o1;
        cur_req = "R10";
        load({2'b00, 8'h00, 2'b10, 8'h00}, '0, o0, o1);
        out_ready = '1;
        in_valid = 2'b01;
        in_data[W-1:0] = 8'h77;
        scan_upd = 1'b1;
        step();
        scan_upd = 1'b0;
        check(acc[0], "R10", "token taken in update cycle", acc[0], 1);
        lane_pass[0] = 0;
        in_data[W-1:0] = 8'h88;
        step();
        in_valid = '0;
        repeat (4) step();
        lane_pass[0] = 1;
        check(expq[0].size() == 0, "R10", "old-mode token delivered", expq[0].size(), 0);
        load('0, '0, o0, o1);
        check(o0[SRW-1:0] == {2'b10, 8'h88}, "R10", "next token drained", o0[SRW-1:0], {2'b10, 8'h88});
        pulse_upd();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run hung actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = '0; in_data = '0; out_ready = '0;
        scan_en = 1'b0; scan_upd = 1'b0; scan_in = '0;
        for (int l = 0; l < NC; l++) begin
            lane_pass[l] = 1; acc[l] = 0; hold_prev[l] = 0; hold_d[l] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_stream();
        t_backpressure();
        t_freeze();
        t_scan_through();
        t_inject();
        t_drain();
        t_same_cycle();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule